// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio for the feedback path of a phase-locked loop. It stands for a two-modulus prescaler, which divides by P or P+1, together with a swallow counter and a main counter. A three-bit mode code selects P and chooses between dual-modulus operation and fixed-divide operation. In dual-modulus operation the swallow count A and the main count B give a total ratio of N = P×B + A. The prescaler uses P+1 for the first A prescaler periods of each output period and P for the remaining B−A periods.

In fixed-divide operation the prescaler always divides by P and A has no effect. A bypass control can also collapse the main counter to a single step, so that P alone sets the ratio. The output is one registered pulse, one input cycle wide, at the end of every N input cycles, for a phase detector. A synchronous reset, or a separate synchronization strobe, restarts the output period from zero. A setting that cannot be divided holds the output low.

Top module: `dmdiv_top`

## Requirements
- R1: While `rst` or `sync_rst` is high at a clock edge, `pulse_o` is low after that edge.
- R2: Mode codes 0, 1, 2, 3 and 4 select dual-modulus operation with P = 2, 4, 8, 16 and 32. Codes 5, 6 and 7 select fixed-divide operation with P = 1, 2 and 3.
- R3: In dual-modulus operation with 1 ≤ B and A ≤ B, `pulse_o` is high after the k-th clock edge following reset release exactly when k is a multiple of N = P×B + A.
- R4: In dual-modulus operation the ratio holds at both ends of the swallow range, A = 0 and A = B. The prescaler count never reaches the modulus in use.
- R5: In fixed-divide operation without bypass, N = P×B, and `a_val` has no effect on the output.
- R6: In fixed-divide operation with `b_bypass` set, N = P, and `b_val` has no effect, even when it is zero.
- R7: In dual-modulus operation `b_bypass` has no effect.
- R8: An invalid setting holds `pulse_o` low. A setting is invalid when B = 0 without an effective bypass, or when dual-modulus operation has A > B.
- R9: A `sync_rst` pulse in the middle of an output period restarts counting, so the next pulse comes N edges after its release.
- R10: When N = 1, `pulse_o` stays high on every edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_rst | input | 1 | Synchronous restart from a synchronization request |
| mode | input | 3 | Prescaler mode code (see R2) |
| a_val | input | A_W | Swallow count A |
| b_val | input | B_W | Main count B |
| b_bypass | input | 1 | Main counter bypass; honoured only in fixed-divide operation |
| pulse_o | output | 1 | Registered output pulse, one per N input cycles |

## Verification
The assertions assume that the mode, A, B and bypass inputs change only while `sync_rst` or `rst` is high, so that a period never runs with a mixed setting. The one-cycle pulse check also relies on this static setting. The stimulus respects it: each new setting, directed or random, is applied on a falling edge together with a one-cycle `sync_rst`. Random settings keep B between 1 and 20 so that periods stay short. About one in eight random settings is made invalid on purpose, with A = B+1.

// File: rtl/dmdiv_pkg.sv
package dmdiv_pkg;
  localparam int MAX_P = 32;
  localparam int PW    = $clog2(MAX_P + 2);

  typedef struct packed {
    logic          fixed;
    logic [PW-1:0] p;
  } presc_cfg_t;

  function automatic presc_cfg_t decode_mode(input logic [2:0] m);
    presc_cfg_t c;
    if (m < 3'd5) begin
      c.fixed = 1'b0;
      c.p     = PW'(2) << m;
    end else begin
      c.fixed = 1'b1;
      c.p     = PW'(m) - PW'(4);
    end
    return c;
  endfunction
endpackage

// File: rtl/dmdiv_cfg.sv
module dmdiv_cfg
  import dmdiv_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic [2:0]     mode,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           b_bypass,
  output logic [PW-1:0]  p,
  output logic           fixed,
  output logic [A_W-1:0] a_eff,
  output logic [B_W-1:0] b_term,
  output logic           cfg_ok
);
  presc_cfg_t dec;
  logic       byp_eff;

  always_comb begin
    dec     = decode_mode(mode);
    p       = dec.p;
    fixed   = dec.fixed;
    byp_eff = dec.fixed & b_bypass;
    a_eff   = dec.fixed ? '0 : a_val;
    b_term  = byp_eff ? B_W'(1) : b_val;
    cfg_ok  = (b_term != '0) &&
              (dec.fixed || ({{(B_W > A_W ? B_W - A_W : 0){1'b0}}, a_val} <= b_val));
  end
endmodule

// File: rtl/dmdiv_presc.sv
module dmdiv_presc
  import dmdiv_pkg::*;
(
  input  logic          clk,
  input  logic          clr,
  input  logic [PW-1:0] p,
  input  logic          use_plus1,
  output logic          wrap
);
  logic [PW-1:0] pc;
  logic [PW-1:0] modulus;

  always_comb begin
    modulus = p + PW'(use_plus1);
    wrap    = (pc == modulus - PW'(1));
  end

  always_ff @(posedge clk) begin
    if (clr)       pc <= '0;
    else if (wrap) pc <= '0;
    else           pc <= pc + PW'(1);
  end

  // R4
  pc_in_range_chk: assert property (@(posedge clk) disable iff (clr)
    pc < modulus);
endmodule

// File: rtl/dmdiv_swallow.sv
module dmdiv_swallow #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           wrap,
  input  logic [A_W-1:0] a_eff,
  input  logic [B_W-1:0] b_term,
  output logic           use_plus1,
  output logic           term
);
  localparam int CW = (A_W > B_W) ? A_W : B_W;
  logic [B_W-1:0] bcnt;

  always_comb begin
    use_plus1 = (CW'(bcnt) < CW'(a_eff));
    term      = wrap && (bcnt == b_term - B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (clr)       bcnt <= '0;
    else if (term) bcnt <= '0;
    else if (wrap) bcnt <= bcnt + B_W'(1);
  end

  // R3
  bcnt_range_chk: assert property (@(posedge clk) disable iff (clr)
    bcnt < b_term);
endmodule

// File: rtl/dmdiv_top.sv
module dmdiv_top
  import dmdiv_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync_rst,
  input  logic [2:0]     mode,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           b_bypass,
  output logic           pulse_o
);
  logic [PW-1:0]  p;
  logic           fixed;
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_term;
  logic           cfg_ok;
  logic           clr;
  logic           wrap;
  logic           use_plus1;
  logic           term;
  logic           n_one;

  dmdiv_cfg #(.A_W(A_W), .B_W(B_W)) cfg_i (
    .mode(mode), .a_val(a_val), .b_val(b_val), .b_bypass(b_bypass),
    .p(p), .fixed(fixed), .a_eff(a_eff), .b_term(b_term), .cfg_ok(cfg_ok)
  );

  assign clr   = rst | sync_rst | ~cfg_ok;
  assign n_one = fixed && (p == PW'(1)) && (b_term == B_W'(1));

  dmdiv_presc presc_i (
    .clk(clk), .clr(clr), .p(p), .use_plus1(use_plus1), .wrap(wrap)
  );

  dmdiv_swallow #(.A_W(A_W), .B_W(B_W)) swal_i (
    .clk(clk), .clr(clr), .wrap(wrap), .a_eff(a_eff), .b_term(b_term),
    .use_plus1(use_plus1), .term(term)
  );

  always_ff @(posedge clk) begin
    if (clr) pulse_o <= 1'b0;
    else     pulse_o <= term;
  end

  // R1
  sync_clears_chk: assert property (@(posedge clk) disable iff (rst)
    sync_rst |=> !pulse_o);
  // R8
  invalid_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> !pulse_o);
  // R3
  one_wide_chk: assert property (@(posedge clk) disable iff (rst || sync_rst)
    (pulse_o && !n_one) |=> !pulse_o);
endmodule

// File: tb/dmdiv_top_tb_top.sv
module dmdiv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_rst = 1'b0;
  logic [2:0]  mode = '0;
  logic [5:0]  a_val = '0;
  logic [12:0] b_val = 13'd1;
  logic        b_bypass = 1'b0;
  logic        pulse_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dmdiv_top #(.A_W(6), .B_W(13)) dut_i (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .mode(mode),
    .a_val(a_val), .b_val(b_val), .b_bypass(b_bypass), .pulse_o(pulse_o)
  );

  function automatic int exp_n(input int m, input int a, input int b, input bit byp);
    int p;
    if (m < 5) begin
      p = 2 << m;
      if (b == 0 || a > b) return 0;
      return p * b + a;
    end
    p = m - 4;
    if (byp) return p;
    if (b == 0) return 0;
    return p * b;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic run_cfg(input int m, input int a, input int b, input bit byp,
                         input int len, input string tag);
    int  n;
    int  lim;
    bit  bad;
    bit  e;
    n = exp_n(m, a, b, byp);
    @(negedge clk);
    mode = 3'(m); a_val = 6'(a); b_val = 13'(b); b_bypass = byp;
    sync_rst = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (pulse_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 pulse during sync: actual=%b expected=0", pulse_o);
    end
    @(negedge clk);
    sync_rst = 1'b0;
    lim = (len > 0) ? len : ((n == 0) ? 60 : 3 * n + 2);
    bad = 0;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk); #1;
      e = (n != 0) && (k % n == 0);
      if (!bad && pulse_o !== e) begin
        bad = 1;
        $display("FAIL %s mode=%0d a=%0d b=%0d byp=%0d edge=%0d: actual=%b expected=%b",
                 tag, m, a, b, byp, k, pulse_o, e);
      end
    end
    checks++;
    if (bad) fails++;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int m, a, b;
    bit byp;
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (5) begin
      @(posedge clk); #1;
      checks++;
      if (pulse_o !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset: actual=%b expected=0", pulse_o);
      end
    end
    @(negedge clk); rst = 1'b0;

    run_cfg(1, 3, 5, 0, 0, "R3");
    run_cfg(0, 0, 4, 0, 0, "R4");
    run_cfg(2, 3, 3, 0, 0, "R4");
    run_cfg(4, 1, 2, 0, 0, "R2");
    run_cfg(3, 2, 3, 0, 0, "R2");
    run_cfg(6, 9, 7, 0, 0, "R5");
    run_cfg(6, 0, 7, 0, 0, "R5");
    run_cfg(7, 0, 0, 1, 0, "R6");
    run_cfg(7, 5, 9, 1, 0, "R6");
    run_cfg(0, 1, 2, 1, 0, "R7");
    run_cfg(1, 6, 5, 0, 0, "R8");
    run_cfg(5, 0, 0, 0, 0, "R8");
    run_cfg(1, 2, 3, 0, 7, "R9");
    run_cfg(1, 2, 3, 0, 0, "R9");
    run_cfg(5, 0, 4, 1, 20, "R10");

    for (int i = 0; i < 30; i++) begin
      m   = int'($urandom % 8);
      b   = 1 + int'($urandom % 20);
      a   = int'($urandom % (b + 1));
      byp = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) a = b + 1;
      run_cfg(m, a, b, byp, 0, (m < 5) ? "R3" : "R5");
    end
    finish_run();
  end
endmodule